// File: doc/BRIEF.md
# Dual-Output Channel Interrupt Combiner

This block gathers completion pulses from a set of transfer channels (sixteen by default) into a sticky pending vector. Two interrupt lines are derived from that vector. Each line has its own channel enable mask and its own software force mask. Either line asserts whenever any enabled channel is pending or forced for that line.

A per-channel quiet input stops a channel's completion pulse from being recorded. Software reaches every state word through a small synchronous register port:

- a write-one-to-clear pending vector;
- per line, a read/write enable mask and a read/write force mask;
- per line, a read-only view of which channels are currently driving that line.

Reads are combinational from the selected address.

Top module: `chan_irq_combiner`

## Requirements
- R1: After reset the pending vector, both enable masks, both force masks, both masked views and both interrupt lines are zero.
- R2: A completion pulse on a channel whose quiet input is low sets that channel's pending bit on the next clock edge, and the bit stays set until software clears it.
- R3: A completion pulse on a channel whose quiet input is high leaves that channel's pending bit unchanged.
- R4: Register map, word addresses on `reg_addr_i`: 0 pending, 1 enable line 0, 2 force line 0, 3 masked line 0, 4 enable line 1, 5 force line 1, 6 masked line 1. Writing 1 to bit n at address 0 clears pending bit n, and writing 0 leaves it unchanged.
- R5: When a clear and a recorded pulse hit the same pending bit in the same cycle, the bit ends up set.
- R6: The masked view of line k equals (pending OR force_k) AND enable_k, with channel n at bit n.
- R7: A force mask holds its value until software writes it again; writing 0 to a bit removes that forced bit.
- R8: Interrupt line k (`irq_o[k]`) is high exactly when its masked view is nonzero.
- R9: Writes to one line's enable or force register change neither the other line's registers nor its interrupt output.
- R10: Writes to the masked views (addresses 3, 6) and to address 7 change no state; address 7 reads zero; data bits 31:16 of every register read zero and are ignored on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CH | Per-channel completion pulse |
| quiet_i | input | NUM_CH | Per-channel quiet mode, blocks recording |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| irq_o | output | NUM_OUT | Interrupt lines |

## Verification
The bench aims at the same-cycle collision of a clear and a pulse on one bit. A design that lets the clear win would lose that event and read the bit back as zero. Quiet channels are pulsed next to active channels, so a design that ignored the quiet input would show an unexpected pending bit. The bench writes to the read-only views and to the unused address, and checks that no enable or force mask changes. It also checks that writes to one line never disturb the other line's masks or output. A forced bit with a zero pending bit must keep its line high over idle cycles, and must release the line once it is written back to zero.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    // Register word addresses; line k occupies LANE_BASE + 3*k .. +2
    localparam int unsigned ADR_PEND  = 0;
    localparam int unsigned LANE_BASE = 1;
    localparam int unsigned LANE_STEP = 3;
    localparam int unsigned OFF_EN    = 0;
    localparam int unsigned OFF_FRC   = 1;
    localparam int unsigned OFF_MSK   = 2;
endpackage

// File: rtl/chan_pend_reg.sv
module chan_pend_reg #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic [NUM_CH-1:0] quiet_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [NUM_CH-1:0] post;

    always_comb begin
        post    = evt_i & ~quiet_i;
        st_d    = st_q;
        // a recorded pulse overrides a clear on the same bit
        st_d.pend = (st_q.pend & ~clr_i) | post;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & ~quiet_i)) |=> ((pend_o & $past(evt_i & ~quiet_i)) == $past(evt_i & ~quiet_i)));

    p_quiet_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(evt_i & ~quiet_i)) == '0));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i)) |=> ((pend_o & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/chan_irq_lane.sv
module chan_irq_lane #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pend_i,
    input  logic              en_we_i,
    input  logic              frc_we_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] frc_o,
    output logic [NUM_CH-1:0] msk_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] frc;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i)  st_d.en  = wdata_i;
        if (frc_we_i) st_d.frc = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign frc_o = st_q.frc;
    assign msk_o = (pend_i | st_q.frc) & st_q.en;
    assign irq_o = |msk_o;

    p_force_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frc_we_i |=> $stable(frc_o));

    p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we_i |=> $stable(en_o));

    p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o == '0) |-> !irq_o);
endmodule

// File: rtl/chan_irq_combiner.sv
module chan_irq_combiner
    import chan_irq_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_OUT = 2,
    parameter int DATA_W  = 32,
    localparam int NUM_ADR = LANE_BASE + LANE_STEP * NUM_OUT,
    localparam int ADDR_W  = $clog2(NUM_ADR + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  evt_i,
    input  logic [NUM_CH-1:0]  quiet_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [NUM_OUT-1:0] irq_o
);
    logic [NUM_CH-1:0] wdata_ch;
    logic [NUM_CH-1:0] pend_clr;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] en_v  [NUM_OUT];
    logic [NUM_CH-1:0] frc_v [NUM_OUT];
    logic [NUM_CH-1:0] msk_v [NUM_OUT];
    logic [NUM_OUT-1:0] en_we, frc_we;

    assign wdata_ch = reg_wdata_i[NUM_CH-1:0];
    assign pend_clr = (reg_wr_i && int'(reg_addr_i) == ADR_PEND) ? wdata_ch : '0;

    chan_pend_reg #(.NUM_CH(NUM_CH)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .quiet_i(quiet_i),
        .clr_i  (pend_clr),
        .pend_o (pend)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
        localparam int ADR_EN  = LANE_BASE + LANE_STEP * k + OFF_EN;
        localparam int ADR_FRC = LANE_BASE + LANE_STEP * k + OFF_FRC;

        assign en_we[k]  = reg_wr_i && (int'(reg_addr_i) == ADR_EN);
        assign frc_we[k] = reg_wr_i && (int'(reg_addr_i) == ADR_FRC);

        chan_irq_lane #(.NUM_CH(NUM_CH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend_i  (pend),
            .en_we_i (en_we[k]),
            .frc_we_i(frc_we[k]),
            .wdata_i (wdata_ch),
            .en_o    (en_v[k]),
            .frc_o   (frc_v[k]),
            .msk_o   (msk_v[k]),
            .irq_o   (irq_o[k])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (int'(reg_addr_i) == ADR_PEND) reg_rdata_o[NUM_CH-1:0] = pend;
        for (int k = 0; k < NUM_OUT; k++) begin
            if (int'(reg_addr_i) == LANE_BASE + LANE_STEP * k + OFF_EN)
                reg_rdata_o[NUM_CH-1:0] = en_v[k];
            if (int'(reg_addr_i) == LANE_BASE + LANE_STEP * k + OFF_FRC)
                reg_rdata_o[NUM_CH-1:0] = frc_v[k];
            if (int'(reg_addr_i) == LANE_BASE + LANE_STEP * k + OFF_MSK)
                reg_rdata_o[NUM_CH-1:0] = msk_v[k];
        end
    end

    logic ro_wr;
    assign ro_wr = reg_wr_i && ((int'(reg_addr_i) >= NUM_ADR) ||
                   ((int'(reg_addr_i) >= LANE_BASE) &&
                    ((int'(reg_addr_i) - LANE_BASE) % LANE_STEP == OFF_MSK)));

    p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ro_wr |=> ($stable(en_v[0]) && $stable(frc_v[0]) &&
                   $stable(en_v[NUM_OUT-1]) && $stable(frc_v[NUM_OUT-1])));

    p_lane_indep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we[0] || frc_we[0]) |=> ($stable(en_v[NUM_OUT-1]) && $stable(frc_v[NUM_OUT-1])));
endmodule

// File: tb/chan_irq_combiner_tb_top.sv
module chan_irq_combiner_tb_top;
    localparam int NCH = 16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_i = '0, quiet_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [1:0]  irq_o;

    always #4 clk = ~clk;

    chan_irq_combiner dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .quiet_i(quiet_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    typedef struct {
        string       tag;
        logic [31:0] exp_data;
        logic [1:0]  exp_irq;
    } item_t;

    item_t sb_q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model built from the requirements
    logic [15:0] m_pend = '0;
    logic [15:0] m_en  [2] = '{16'h0, 16'h0};
    logic [15:0] m_frc [2] = '{16'h0, 16'h0};

    function automatic logic [15:0] m_msk(int k);
        return (m_pend | m_frc[k]) & m_en[k];
    endfunction

    task automatic cycle(input logic [15:0] evt, input logic [15:0] qt,
                         input bit wr, input int adr, input logic [31:0] dat);
        @(negedge clk);
        evt_i = evt; quiet_i = qt; reg_wr_i = wr;
        reg_addr_i = 3'(adr); reg_wdata_i = dat;
        begin
            logic [15:0] clr;
            clr = (wr && adr == 0) ? dat[15:0] : 16'h0;
            m_pend = (m_pend & ~clr) | (evt & ~qt);
            if (wr && adr == 1) m_en[0]  = dat[15:0];
            if (wr && adr == 2) m_frc[0] = dat[15:0];
            if (wr && adr == 4) m_en[1]  = dat[15:0];
            if (wr && adr == 5) m_frc[1] = dat[15:0];
        end
        @(negedge clk);
        evt_i = '0; quiet_i = '0; reg_wr_i = 1'b0;
    endtask

    task automatic wr(input int adr, input logic [31:0] dat);
        cycle('0, '0, 1'b1, adr, dat);
    endtask

    task automatic check(input string tag, input int adr);
        item_t it;
        @(negedge clk);
        reg_addr_i = 3'(adr);
        it.tag = tag;
        case (adr)
            0: it.exp_data = {16'h0, m_pend};
            1: it.exp_data = {16'h0, m_en[0]};
            2: it.exp_data = {16'h0, m_frc[0]};
            3: it.exp_data = {16'h0, m_msk(0)};
            4: it.exp_data = {16'h0, m_en[1]};
            5: it.exp_data = {16'h0, m_frc[1]};
            6: it.exp_data = {16'h0, m_msk(1)};
            default: it.exp_data = '0;
        endcase
        it.exp_irq = {|m_msk(1), |m_msk(0)};
        sb_q.push_back(it);
    endtask

    // monitor: pops expectations and compares, away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (reg_rdata_o !== it.exp_data || irq_o !== it.exp_irq) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, reg_rdata_o, irq_o, it.exp_data, it.exp_irq);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: everything zero after reset
        for (int a = 0; a < 7; a++) check("R1 reset", a);
        // R2: unquiet pulses set pending bits
        cycle(16'h0408, 16'h0, 1'b0, 0, 0);
        check("R2 pulse sets", 0);
        cycle(16'h0, 16'h0, 1'b0, 0, 0);
        check("R2 sticky", 0);
        // R3: quiet channel 5 ignored, channel 6 recorded
        cycle(16'h0060, 16'h0020, 1'b0, 0, 0);
        check("R3 quiet", 0);
        // R6/R8: enable line 0
        wr(1, 32'h0000_0408);
        check("R6 masked0", 3);
        check("R8 irq0", 1);
        check("R9 line1 untouched", 6);
        // R4: clear bit 3, then write 0
        wr(0, 32'h0000_0008);
        check("R4 w1c", 0);
        wr(0, 32'h0);
        check("R4 write0", 0);
        // R5: pulse and clear on bit 10 same cycle; bit 6 cleared
        cycle(16'h0400, 16'h0, 1'b1, 0, 32'h0000_0440);
        check("R5 event wins", 0);
        // R7: force line 1
        wr(5, 32'h0000_8001);
        wr(4, 32'h0000_0001);
        check("R7 force1", 5);
        check("R6 masked1", 6);
        check("R9 line0 kept", 3);
        check("R9 en0 kept", 1);
        repeat (5) cycle('0, '0, 1'b0, 0, 0);
        check("R7 force persists", 6);
        // R10: writes to read-only and unused addresses
        wr(3, 32'h0000_ffff);
        wr(6, 32'h0000_ffff);
        wr(7, 32'h0000_ffff);
        check("R10 en0 after ro write", 1);
        check("R10 frc0 after ro write", 2);
        check("R10 en1 after ro write", 4);
        check("R10 addr7", 7);
        wr(2, 32'hffff_0000);
        check("R10 upper bits", 2);
        // R7/R8: removing force drops line 1
        wr(5, 32'h0);
        check("R7 force cleared", 5);
        check("R8 irq1 low", 6);
        // R8: disabling line 0 drops it
        wr(1, 32'h0);
        check("R8 irq0 low", 3);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule